// File: doc/BRIEF.md
# Partial-Write Register File with Byte-Lane Operand Decoding

This block holds sixteen 64-bit general registers. An instruction can write or read a register at any of four operand widths: 8, 16, 32 or 64 bits. Each access names its register with a 3-bit field. It may also carry a prefix-present flag and an extension bit that goes with that prefix. A small decoder turns the field, the prefix information and the width into a register index and a byte lane.

Without the prefix, byte codes 4 to 7 select bits 15:8 of registers 0 to 3. With the prefix, the same codes select the low byte of registers 4 to 7, and the extension bit reaches registers 8 to 15.

A narrow write must leave the unaddressed bits of the register as they were. The block therefore merges the incoming lane with the old contents. A 32-bit write clears the top half instead. The width select is already resolved upstream; for example, an operand-size override turns a 32-bit default into the 16-bit code.

The merge runs in one of two modes, chosen by a parameter:
- In the single-cycle mode the merge happens in the write cycle.
- In the two-cycle mode an 8- or 16-bit write spends one extra cycle merging, and `busy` is high during that cycle. A read of the register being merged returns the merged value during that cycle.

Two independent read ports return the selected part of a register zero-extended to 64 bits.

Top module: `partial_regfile`

## Requirements
- R1: A synchronous active-high `rst` clears every register to zero and drives `busy` low at the next clock edge.
- R2: Without the prefix (`*_pfx`=0), an 8-bit access (`*_size`=0) uses the field as follows. Codes 0–3 select bits 7:0 of registers 0–3. Codes 4–7 select bits 15:8 of registers 0–3. The extension bit is ignored, and registers 4–15 cannot be reached at byte width.
- R3: With the prefix, an 8-bit access selects bits 7:0 of register {ext,field}, which is any of 0–15. Bits 15:8 are never selected.
- R4: For 16-, 32- and 64-bit accesses (`*_size` = 1, 2, 3) the index is {ext,field} with the prefix and {0,field} without it.
- R5: An 8-bit write replaces only the addressed byte lane, and a 16-bit write replaces only bits 15:0. All other bits keep their previous value.
- R6: A 32-bit write stores data bits 31:0 and clears bits 63:32. A 64-bit write stores all 64 bits.
- R7: Each of the two read ports returns the selected part, zero-extended to 64 bits: a byte lane, bits 15:0, bits 31:0 or the whole register. The two ports work independently in the same cycle.
- R8: With MERGE_2CYC=0, a write of any width is visible on the read ports in the cycle after its clock edge, and `busy` stays low.
- R9: With MERGE_2CYC=1, an accepted 8- or 16-bit write raises `busy` for exactly the following cycle, and the register holds the merged value after that cycle. 32- and 64-bit writes complete like R8 and do not raise `busy`.
- R10: With MERGE_2CYC=1, while `busy` is high, a read of the register being merged returns the fully merged value.
- R11: With MERGE_2CYC=1, `wr_en` asserted while `busy` is high is not accepted, and no register changes because of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_field | input | 3 | Register field of the write operand |
| wr_ext | input | 1 | Extension bit of the write operand (used only with prefix) |
| wr_pfx | input | 1 | Prefix present for the write operand |
| wr_size | input | 2 | Write width: 0=8, 1=16, 2=32, 3=64 bits |
| wr_data | input | 64 | Write data, right-aligned |
| ra_field | input | 3 | Register field, read port A |
| ra_ext | input | 1 | Extension bit, read port A |
| ra_pfx | input | 1 | Prefix present, read port A |
| ra_size | input | 2 | Read width, port A (same encoding as wr_size) |
| ra_data | output | 64 | Zero-extended read result, port A |
| rb_field | input | 3 | Register field, read port B |
| rb_ext | input | 1 | Extension bit, read port B |
| rb_pfx | input | 1 | Prefix present, read port B |
| rb_size | input | 2 | Read width, port B |
| rb_data | output | 64 | Zero-extended read result, port B |
| busy | output | 1 | Merge cycle in progress (two-cycle mode only) |

## Verification
The read ports are combinational, so a read result is due in the same cycle as its select inputs. The bench samples it one time unit after changing those inputs, half a clock away from the edges.

A write that completes in one cycle shows on the read ports at the falling edge after its rising edge. In the two-cycle mode, `busy` and the forwarded merged value are due at that same falling edge, and the stored value and the return of `busy` to low are due one full cycle later. The bench drives both merge modes side by side from the same stimulus and checks each at exactly those falling edges.

// File: rtl/prf_pkg.sv
package prf_pkg;
   typedef enum logic [1:0] {
      OPW_8  = 2'd0,
      OPW_16 = 2'd1,
      OPW_32 = 2'd2,
      OPW_64 = 2'd3
   } opw_e;

   localparam int IDX_W = 4;

   typedef struct packed {
      logic [IDX_W-1:0] idx;
      logic             hi;    // byte lane 15:8 instead of 7:0
   } operand_t;
endpackage

// File: rtl/prf_decode.sv
module prf_decode
   import prf_pkg::*;
(
   input  logic [2:0] field,
   input  logic       ext,
   input  logic       pfx,
   input  opw_e       width,
   output operand_t   opnd
);
   always_comb begin
      opnd.idx = {1'b0, field};
      opnd.hi  = 1'b0;
      if (pfx) begin
         opnd.idx = {ext, field};
      end else if (width == OPW_8 && field[2]) begin
         opnd.idx = {2'b00, field[1:0]};
         opnd.hi  = 1'b1;
      end
   end
endmodule

// File: rtl/prf_merge.sv
module prf_merge
   import prf_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] old_val,
   input  logic [XLEN-1:0] new_val,
   input  opw_e            width,
   input  logic            hi,
   output logic [XLEN-1:0] merged
);
   always_comb begin
      merged = old_val;
      case (width)
         OPW_8: begin
            if (hi) merged[15:8] = new_val[7:0];
            else    merged[7:0]  = new_val[7:0];
         end
         OPW_16:  merged[15:0] = new_val[15:0];
         OPW_32:  merged = {{(XLEN-32){1'b0}}, new_val[31:0]};
         default: merged = new_val;
      endcase
   end
endmodule

// File: rtl/prf_extract.sv
module prf_extract
   import prf_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] src,
   input  opw_e            width,
   input  logic            hi,
   output logic [XLEN-1:0] dout
);
   always_comb begin
      dout = '0;
      case (width)
         OPW_8: begin
            if (hi) dout[7:0] = src[15:8];
            else    dout[7:0] = src[7:0];
         end
         OPW_16:  dout[15:0] = src[15:0];
         OPW_32:  dout[31:0] = src[31:0];
         default: dout = src;
      endcase
   end
endmodule

// File: rtl/partial_regfile.sv
module partial_regfile
   import prf_pkg::*;
#(
   parameter int NREGS      = 16,
   parameter int XLEN       = 64,
   parameter bit MERGE_2CYC = 1'b0
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            wr_en,
   input  logic [2:0]      wr_field,
   input  logic            wr_ext,
   input  logic            wr_pfx,
   input  logic [1:0]      wr_size,
   input  logic [XLEN-1:0] wr_data,
   input  logic [2:0]      ra_field,
   input  logic            ra_ext,
   input  logic            ra_pfx,
   input  logic [1:0]      ra_size,
   output logic [XLEN-1:0] ra_data,
   input  logic [2:0]      rb_field,
   input  logic            rb_ext,
   input  logic            rb_pfx,
   input  logic [1:0]      rb_size,
   output logic [XLEN-1:0] rb_data,
   output logic            busy
);
   localparam int IDXW = $clog2(NREGS);

   if (NREGS != (1 << IDX_W)) begin : g_bad_nregs
      $error("partial_regfile: NREGS must equal 2**IDX_W");
   end
   if (XLEN != 64) begin : g_bad_xlen
      $error("partial_regfile: XLEN must be 64");
   end

   // ---------------- operand decode ----------------
   operand_t wr_op, ra_op, rb_op;
   opw_e     wr_w, ra_w, rb_w;
   assign wr_w = opw_e'(wr_size);
   assign ra_w = opw_e'(ra_size);
   assign rb_w = opw_e'(rb_size);

   prf_decode u_dec_wr (.field(wr_field), .ext(wr_ext), .pfx(wr_pfx), .width(wr_w), .opnd(wr_op));
   prf_decode u_dec_ra (.field(ra_field), .ext(ra_ext), .pfx(ra_pfx), .width(ra_w), .opnd(ra_op));
   prf_decode u_dec_rb (.field(rb_field), .ext(rb_ext), .pfx(rb_pfx), .width(rb_w), .opnd(rb_op));

   // R3
   pfx_no_high_lane_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_pfx) |-> !wr_op.hi);

   // ---------------- storage ----------------
   logic [XLEN-1:0] regs [NREGS];
   logic            commit_en;
   logic [IDXW-1:0] commit_idx;
   logic [XLEN-1:0] commit_val;
   opw_e            commit_w;
   logic            fwd_v;
   logic [IDXW-1:0] fwd_idx;
   logic [XLEN-1:0] fwd_val;
   logic [XLEN-1:0] wr_merged;

   prf_merge #(.XLEN(XLEN)) u_merge_wr (
      .old_val(regs[wr_op.idx]), .new_val(wr_data), .width(wr_w),
      .hi(wr_op.hi), .merged(wr_merged));

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NREGS; i++) regs[i] <= '0;
      end else if (commit_en) begin
         regs[commit_idx] <= commit_val;
      end
   end

   // R5
   partial_keeps_upper_chk: assert property (@(posedge clk) disable iff (rst)
      (commit_en && (commit_w == OPW_8 || commit_w == OPW_16))
         |-> commit_val[XLEN-1:16] == regs[commit_idx][XLEN-1:16]);

   // R6
   dword_zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
      (commit_en && commit_w == OPW_32) |-> commit_val[XLEN-1:32] == '0);

   // R6 R8
   full_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !busy && wr_w == OPW_64) |=> regs[$past(wr_op.idx)] == $past(wr_data));

   // ---------------- merge timing variants ----------------
   if (MERGE_2CYC) begin : g_two
      logic            pend_v;
      logic [IDXW-1:0] pend_idx;
      logic            pend_hi;
      opw_e            pend_w;
      logic [XLEN-1:0] pend_data;
      logic [XLEN-1:0] pend_merged;
      logic            accept;
      logic            wr_partial;

      assign wr_partial = (wr_w == OPW_8) || (wr_w == OPW_16);
      assign accept     = wr_en && !pend_v;

      always_ff @(posedge clk) begin
         if (rst) begin
            pend_v    <= 1'b0;
            pend_idx  <= '0;
            pend_hi   <= 1'b0;
            pend_w    <= OPW_8;
            pend_data <= '0;
         end else begin
            pend_v <= accept && wr_partial;
            if (accept && wr_partial) begin
               pend_idx  <= wr_op.idx;
               pend_hi   <= wr_op.hi;
               pend_w    <= wr_w;
               pend_data <= wr_data;
            end
         end
      end

      prf_merge #(.XLEN(XLEN)) u_merge_pend (
         .old_val(regs[pend_idx]), .new_val(pend_data), .width(pend_w),
         .hi(pend_hi), .merged(pend_merged));

      assign commit_en  = pend_v || (accept && !wr_partial);
      assign commit_idx = pend_v ? pend_idx : wr_op.idx;
      assign commit_val = pend_v ? pend_merged : wr_merged;
      assign commit_w   = pend_v ? pend_w : wr_w;
      assign busy       = pend_v;
      assign fwd_v      = pend_v;
      assign fwd_idx    = pend_idx;
      assign fwd_val    = pend_merged;

      // R9
      partial_raises_busy_chk: assert property (@(posedge clk) disable iff (rst)
         (wr_en && !busy && wr_partial) |=> busy);

      // R9 R11
      busy_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
         busy |=> !busy);
   end else begin : g_one
      assign commit_en  = wr_en;
      assign commit_idx = wr_op.idx;
      assign commit_val = wr_merged;
      assign commit_w   = wr_w;
      assign busy       = 1'b0;
      assign fwd_v      = 1'b0;
      assign fwd_idx    = '0;
      assign fwd_val    = '0;
   end

   // R1
   reset_idle_chk: assert property (@(posedge clk) rst |=> !busy);

   // ---------------- read ports ----------------
   logic [XLEN-1:0] ra_src, rb_src;
   assign ra_src = (fwd_v && ra_op.idx == fwd_idx) ? fwd_val : regs[ra_op.idx];
   assign rb_src = (fwd_v && rb_op.idx == fwd_idx) ? fwd_val : regs[rb_op.idx];

   prf_extract #(.XLEN(XLEN)) u_ext_ra (.src(ra_src), .width(ra_w), .hi(ra_op.hi), .dout(ra_data));
   prf_extract #(.XLEN(XLEN)) u_ext_rb (.src(rb_src), .width(rb_w), .hi(rb_op.hi), .dout(rb_data));

   // R7
   byte_read_zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
      (ra_w == OPW_8) |-> ra_data[XLEN-1:8] == '0);
endmodule

// File: tb/partial_regfile_test.sv
`timescale 1ns/1ps
module partial_regfile_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en_a = 1'b0, wr_en_b = 1'b0;
   logic [2:0]  wr_field = '0;
   logic        wr_ext = 1'b0, wr_pfx = 1'b0;
   logic [1:0]  wr_size = '0;
   logic [63:0] wr_data = '0;
   logic [2:0]  ra_field = '0, rb_field = '0;
   logic        ra_ext = 1'b0, ra_pfx = 1'b0, rb_ext = 1'b0, rb_pfx = 1'b0;
   logic [1:0]  ra_size = '0, rb_size = '0;
   logic [63:0] ra_a, rb_a, ra_b, rb_b;
   logic        busy_a, busy_b;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [63:0] model [16];

   always #2.5 clk = ~clk;

   partial_regfile #(.MERGE_2CYC(1'b0)) uut (
      .clk(clk), .rst(rst), .wr_en(wr_en_a), .wr_field(wr_field), .wr_ext(wr_ext),
      .wr_pfx(wr_pfx), .wr_size(wr_size), .wr_data(wr_data),
      .ra_field(ra_field), .ra_ext(ra_ext), .ra_pfx(ra_pfx), .ra_size(ra_size), .ra_data(ra_a),
      .rb_field(rb_field), .rb_ext(rb_ext), .rb_pfx(rb_pfx), .rb_size(rb_size), .rb_data(rb_a),
      .busy(busy_a));

   partial_regfile #(.MERGE_2CYC(1'b1)) uut_m2 (
      .clk(clk), .rst(rst), .wr_en(wr_en_b), .wr_field(wr_field), .wr_ext(wr_ext),
      .wr_pfx(wr_pfx), .wr_size(wr_size), .wr_data(wr_data),
      .ra_field(ra_field), .ra_ext(ra_ext), .ra_pfx(ra_pfx), .ra_size(ra_size), .ra_data(ra_b),
      .rb_field(rb_field), .rb_ext(rb_ext), .rb_pfx(rb_pfx), .rb_size(rb_size), .rb_data(rb_b),
      .busy(busy_b));

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // bench-side operand interpretation, from the requirements
   function automatic int sel_idx(input logic [2:0] f, input logic e, input logic p, input logic [1:0] s);
      if (p) return int'({e, f});
      if (s == 2'd0 && f[2]) return int'(f[1:0]);
      return int'(f);
   endfunction

   function automatic bit sel_hi(input logic [2:0] f, input logic p, input logic [1:0] s);
      return !p && s == 2'd0 && f[2];
   endfunction

   function automatic logic [63:0] part_of(input logic [63:0] v, input logic [1:0] s, input bit hi);
      case (s)
         2'd0:    return hi ? {56'd0, v[15:8]} : {56'd0, v[7:0]};
         2'd1:    return {48'd0, v[15:0]};
         2'd2:    return {32'd0, v[31:0]};
         default: return v;
      endcase
   endfunction

   function automatic void model_write(input logic [2:0] f, input logic e, input logic p,
                                       input logic [1:0] s, input logic [63:0] d);
      int i = sel_idx(f, e, p, s);
      bit h = sel_hi(f, p, s);
      case (s)
         2'd0:    if (h) model[i][15:8] = d[7:0]; else model[i][7:0] = d[7:0];
         2'd1:    model[i][15:0] = d[15:0];
         2'd2:    model[i] = {32'd0, d[31:0]};
         default: model[i] = d;
      endcase
   endfunction

   task automatic set_ra(input logic [2:0] f, input logic e, input logic p, input logic [1:0] s);
      ra_field = f; ra_ext = e; ra_pfx = p; ra_size = s;
   endtask

   task automatic set_rb_full(input int i);
      rb_field = i[2:0]; rb_ext = i[3]; rb_pfx = 1'b1; rb_size = 2'd3;
   endtask

   // write to both instances and check timing of each merge mode
   task automatic write_both(input string tag, input logic [2:0] f, input logic e, input logic p,
                             input logic [1:0] s, input logic [63:0] d);
      int i = sel_idx(f, e, p, s);
      bit partial = (s < 2'd2);
      @(negedge clk);
      wr_field = f; wr_ext = e; wr_pfx = p; wr_size = s; wr_data = d;
      wr_en_a = 1'b1; wr_en_b = 1'b1;
      @(negedge clk);
      wr_en_a = 1'b0; wr_en_b = 1'b0;
      model_write(f, e, p, s, d);
      set_ra(f, e, p, s);
      set_rb_full(i);
      #1;
      chk({tag, " R8 busy low one-cycle"}, {63'd0, busy_a}, 64'd0);
      chk({tag, " R9 busy after write"}, {63'd0, busy_b}, {63'd0, partial});
      chk({tag, " R8 read one-cycle"}, rb_a, model[i]);
      if (partial) chk({tag, " R10 forwarded read"}, rb_b, model[i]);
      chk({tag, " R7 part read"}, ra_a, part_of(model[i], s, sel_hi(f, p, s)));
      @(negedge clk);
      #1;
      chk({tag, " R9 busy drops"}, {63'd0, busy_b}, 64'd0);
      chk({tag, " R9 stored two-cycle"}, rb_b, model[i]);
   endtask

   task automatic full_check(input string tag, input int i);
      set_rb_full(i);
      #1;
      chk(tag, rb_a, model[i]);
      chk(tag, rb_b, model[i]);
   endtask

   task automatic t_reset();
      for (int i = 0; i < 16; i++) model[i] = '0;
      full_check("R1 reg0 cleared", 0);
      full_check("R1 reg5 cleared", 5);
      full_check("R1 reg15 cleared", 15);
      chk("R1 busy one-cycle", {63'd0, busy_a}, 64'd0);
      chk("R1 busy two-cycle", {63'd0, busy_b}, 64'd0);
   endtask

   task automatic t_fill();
      for (int i = 0; i < 16; i++) begin
         logic [7:0] k = 8'(i * 17 + 3);
         write_both("R4 R6 qword fill", 3'(i), i[3], 1'b1, 2'd3,
                    {8{k}} ^ 64'h0F1E_2D3C_4B5A_6978);
      end
   endtask

   task automatic t_legacy_bytes();
      write_both("R2 high byte code4", 3'd4, 1'b0, 1'b0, 2'd0, 64'hAB);
      write_both("R2 low byte code1 ext ignored", 3'd1, 1'b1, 1'b0, 2'd0, 64'h5C);
      full_check("R2 reg4 untouched", 4);
      full_check("R2 reg9 untouched", 9);
      set_ra(3'd4, 1'b0, 1'b0, 2'd0); #1;
      chk("R2 R7 read code4 no prefix", ra_a, 64'hAB);
      write_both("R4 qword no prefix ext ignored", 3'd5, 1'b1, 1'b0, 2'd3, 64'hCAFE_F00D_1234_0001);
      full_check("R4 reg13 untouched", 13);
   endtask

   task automatic t_prefix_bytes();
      write_both("R3 low byte reg4", 3'd4, 1'b0, 1'b1, 2'd0, 64'h77);
      write_both("R3 low byte reg15", 3'd7, 1'b1, 1'b1, 2'd0, 64'h99);
      set_ra(3'd4, 1'b0, 1'b1, 2'd0); #1;
      chk("R3 prefixed code4 reads reg4 low", ra_a, 64'h77);
      full_check("R3 reg0 high byte kept", 0);
   endtask

   task automatic t_word_dword();
      write_both("R5 word reg2", 3'd2, 1'b0, 1'b0, 2'd1, 64'hFFFF_0000_0000_BEEF);
      full_check("R5 reg2 upper kept", 2);
      write_both("R6 dword reg11", 3'd3, 1'b1, 1'b1, 2'd2, 64'hFFFF_FFFF_1234_5678);
      full_check("R6 reg11 zero extended", 11);
   endtask

   task automatic t_two_ports();
      set_ra(3'd2, 1'b0, 1'b0, 2'd2);
      rb_field = 3'd3; rb_ext = 1'b1; rb_pfx = 1'b1; rb_size = 2'd1;
      #1;
      chk("R7 port A dword reg2", ra_a, {32'd0, model[2][31:0]});
      chk("R7 port B word reg11", rb_a, {48'd0, model[11][15:0]});
      chk("R7 port B word reg11 two-cycle", rb_b, {48'd0, model[11][15:0]});
   endtask

   task automatic t_write_while_busy();
      @(negedge clk);
      wr_field = 3'd6; wr_ext = 1'b0; wr_pfx = 1'b1; wr_size = 2'd0; wr_data = 64'h11;
      wr_en_a = 1'b1; wr_en_b = 1'b1;
      @(negedge clk);
      wr_en_a = 1'b0;
      model_write(3'd6, 1'b0, 1'b1, 2'd0, 64'h11);
      #1;
      chk("R11 busy before blocked write", {63'd0, busy_b}, 64'd1);
      wr_field = 3'd7; wr_pfx = 1'b1; wr_size = 2'd3; wr_data = 64'hDEAD_DEAD_DEAD_DEAD;
      @(negedge clk);
      wr_en_b = 1'b0;
      @(negedge clk);
      full_check("R11 reg7 unchanged by write during busy", 7);
      full_check("R11 reg6 merged byte", 6);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_fill();
      t_legacy_bytes();
      t_prefix_bytes();
      t_word_dword();
      t_two_ports();
      t_write_while_busy();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end
endmodule